// File: doc/BRIEF.md
# Tagged Floating-Point Register Stack

This block holds the eight extended-precision operand registers of a numeric coprocessor. Each register is 80 bits wide: a sign bit, a 15-bit exponent and a 64-bit significand. The registers form a circular stack. A 3-bit top pointer names the current stack top, and every register operand is an offset from that pointer, so ST(k) is physical register (top + k) mod 8. A 2-bit tag per register records whether the register is empty or what class of value it holds. The tags are used to detect stack overflow and underflow.

The surrounding datapath issues one operation per cycle on `op_code`/`op_idx` with `op_valid` high. Operands enter on `wr_data` and leave on `rd_data`, which always shows ST(`op_idx`). The block also keeps the 16-bit status word. That word holds sticky exception flags, a masked summary bit, condition codes, the top field and a busy bit. The summary bit is also driven out as an interrupt request. Arithmetic on register contents and memory transfers are done elsewhere.

All state changes take effect at the rising clock edge that samples the operation. `rd_data`, `tag_word`, `status_word` and `irq` are combinational views of the state and of `mask`.

Top module: `fp_regstack`

## Requirements
- R1: After reset the top pointer is 0, every tag is empty (`tag_word` = 16'hFFFF), `status_word` is 0 and `irq` is low.
- R2: Push (op_code 1) decrements top modulo 8, then writes `wr_data` into the new ST(0). Its tag is set by class: 00 when the exponent is neither all zeros nor all ones; 01 when exponent and significand are both zero; 10 when the exponent is all ones, or the exponent is zero with a non-zero significand.
- R3: Pop (op_code 2) sets the tag of the old ST(0) to 11 (empty), then increments top modulo 8.
- R4: A push whose target register is not empty is a stack overflow. It sets status bit 0 and leaves top, tags and data unchanged.
- R5: Each of these is a stack underflow: pop with ST(0) empty, read (op_code 3) of an empty ST(k), or exchange with ST(0) or ST(k) empty. An underflow sets status bit 0 and leaves top, tags and data unchanged.
- R6: Register offsets are relative. ST(k) is physical register (top+k) mod 8, both for `rd_data` and for write (op_code 4). A write stores `wr_data` with its class tag. Physical register i's tag appears in `tag_word[2i+1:2i]`.
- R7: Exchange (op_code 5) swaps the data and the tags of ST(0) and ST(k).
- R8: Increment-pointer (op_code 6) adds 1 to top and decrement-pointer (op_code 7) subtracts 1, both modulo 8. Neither changes tags or data.
- R9: Free (op_code 8) sets the tag of ST(k) to 11. It does not change top or the register's data.
- R10: Raise (op_code 13) ORs `exc_in` into status bits 5:0. Stack faults also set bit 0. These flags are sticky until clear-exceptions or initialise.
- R11: Status bit 7 and `irq` are high exactly when some flag in bits 5:0 is set with its `mask` bit clear. They follow `mask` without a clock edge.
- R12: Set-codes (op_code 11) loads `cc_in[0]`, `cc_in[1]`, `cc_in[2]` and `cc_in[3]` into status bits 8, 9, 10 and 14. Set-busy (op_code 12) sets bit 15. Bits 13:11 always show top.
- R13: Clear-exceptions (op_code 10) clears bits 5:0, 7 and 15 and keeps the codes and top. Initialise (op_code 9) clears the whole status word, sets top to 0 and marks all tags empty, without altering register data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation selector |
| op_idx | input | 3 | Register offset k from top |
| wr_data | input | 80 | Operand for push and write |
| exc_in | input | 6 | Exception flags to accumulate on raise |
| cc_in | input | 4 | Condition codes for set-codes |
| mask | input | 6 | Exception mask, 1 masks a flag |
| rd_data | output | 80 | Contents of ST(op_idx) |
| tag_word | output | 16 | All eight tags, physical order |
| status_word | output | 16 | Status word |
| irq | output | 1 | Unmasked exception pending |

## Verification
The bench pushes into the register just before top while top sits at 0, so a pointer that does not wrap would overflow a register other than physical 7. It fills all eight registers and pushes once more. A design that ignored the tag would overwrite the deepest entry instead of flagging an overflow. It pops, reads and exchanges on empty registers. Offsets are checked after top has moved, so a design that addressed registers absolutely would return the wrong data or free the wrong tag. The status tests change `mask` with no clock and clear exceptions while codes are set. A summary bit that was registered, or a clear that wiped the codes or top, shows up at the ports.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  localparam int FLAG_N = 6;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } stk_tag_e;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PUSH   = 4'd1,
    OP_POP    = 4'd2,
    OP_READ   = 4'd3,
    OP_WRITE  = 4'd4,
    OP_XCHG   = 4'd5,
    OP_INCP   = 4'd6,
    OP_DECP   = 4'd7,
    OP_FREE   = 4'd8,
    OP_INIT   = 4'd9,
    OP_CLEX   = 4'd10,
    OP_SETCC  = 4'd11,
    OP_SETBSY = 4'd12,
    OP_RAISE  = 4'd13
  } stk_op_e;

  // Any flag left unmasked makes the summary true.
  function automatic logic flag_summary(input logic [FLAG_N-1:0] flags,
                                        input logic [FLAG_N-1:0] msk);
    return |(flags & ~msk);
  endfunction

endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_init,
  input  logic             ptr_inc,
  input  logic             ptr_dec,
  output logic [PTR_W-1:0] top_q
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
    end else if (ptr_init) begin
      top_q <= '0;
    end else if (ptr_inc) begin
      top_q <= top_q + ONE;
    end else if (ptr_dec) begin
      top_q <= top_q - ONE;
    end
  end

endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 80,
  parameter int PTR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               all_empty,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_addr,
  input  logic [W-1:0]       wr_val,
  input  stk_tag_e           wr_tag,
  input  logic               sw_en,
  input  logic [PTR_W-1:0]   sw_a,
  input  logic [PTR_W-1:0]   sw_b,
  input  logic               fr_en,
  input  logic [PTR_W-1:0]   fr_addr,
  input  logic [PTR_W-1:0]   rd_addr,
  output logic [W-1:0]       rd_val,
  output logic [2*DEPTH-1:0] tags_flat
);

  logic [W-1:0] mem [DEPTH];
  stk_tag_e     tg  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
        tg[i]  <= TAG_EMPTY;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (all_empty) begin
          tg[i] <= TAG_EMPTY;
        end else if (wr_en && wr_addr == PTR_W'(i)) begin
          mem[i] <= wr_val;
          tg[i]  <= wr_tag;
        end else if (sw_en && sw_a == PTR_W'(i)) begin
          mem[i] <= mem[sw_b];
          tg[i]  <= tg[sw_b];
        end else if (sw_en && sw_b == PTR_W'(i)) begin
          mem[i] <= mem[sw_a];
          tg[i]  <= tg[sw_a];
        end else if (fr_en && fr_addr == PTR_W'(i)) begin
          tg[i] <= TAG_EMPTY;
        end
      end
    end
  end

  assign rd_val = mem[rd_addr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag_pack
    assign tags_flat[2*g +: 2] = tg[g];
  end

endmodule

// File: rtl/fpstk_status.sv
module fpstk_status
  import fpstk_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_init,
  input  logic              st_clex,
  input  logic [FLAG_N-1:0] raise_vec,
  input  logic              cc_we,
  input  logic [3:0]        cc_val,
  input  logic              busy_set,
  input  logic [FLAG_N-1:0] msk,
  input  logic [PTR_W-1:0]  top,
  output logic [15:0]       sword,
  output logic              summ
);

  logic [FLAG_N-1:0] flags_q;
  logic [3:0]        cc_q;
  logic              busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cc_q    <= '0;
      busy_q  <= 1'b0;
    end else begin
      if (st_init || st_clex) flags_q <= '0;
      else                    flags_q <= flags_q | raise_vec;

      if (st_init)    cc_q <= '0;
      else if (cc_we) cc_q <= cc_val;

      if (st_init || st_clex) busy_q <= 1'b0;
      else if (busy_set)      busy_q <= 1'b1;
    end
  end

  assign summ = flag_summary(flags_q, msk);

  always_comb begin
    sword        = '0;
    sword[5:0]   = flags_q;
    sword[7]     = summ;
    sword[8]     = cc_q[0];
    sword[9]     = cc_q[1];
    sword[10]    = cc_q[2];
    sword[13:11] = 3'(top);
    sword[14]    = cc_q[3];
    sword[15]    = busy_q;
  end

endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
  import fpstk_pkg::*;
#(
  parameter int STK_DEPTH = 8,
  parameter int EXP_W     = 15,
  parameter int SIG_W     = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [2:0]             op_idx,
  input  logic [79:0]            wr_data,
  input  logic [5:0]             exc_in,
  input  logic [3:0]             cc_in,
  input  logic [5:0]             mask,
  output logic [79:0]            rd_data,
  output logic [15:0]            tag_word,
  output logic [15:0]            status_word,
  output logic                   irq
);

  localparam int W     = 1 + EXP_W + SIG_W;
  localparam int PTR_W = $clog2(STK_DEPTH);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  // Class tag of an operand from its exponent and significand.
  function automatic stk_tag_e classify(input logic [W-1:0] v);
    logic [EXP_W-1:0] e;
    logic [SIG_W-1:0] s;
    e = v[W-2 -: EXP_W];
    s = v[SIG_W-1:0];
    if (&e)            return TAG_SPECIAL;
    else if (e == '0)  return (s == '0) ? TAG_ZERO : TAG_SPECIAL;
    else               return TAG_VALID;
  endfunction

  function automatic logic is_empty(input logic [2*STK_DEPTH-1:0] tw,
                                    input logic [PTR_W-1:0] p);
    return tw[2*p +: 2] == TAG_EMPTY;
  endfunction

  logic [PTR_W-1:0]      top;
  logic [PTR_W-1:0]      push_slot;
  logic [PTR_W-1:0]      idx_phys;
  logic [2*STK_DEPTH-1:0] tags;
  logic [W-1:0]          rd_val;
  stk_op_e               op;

  // named internal events, observed by the checker
  logic ev_overflow, ev_underflow, ev_push_ok, ev_pop_ok, ev_xchg_ok;
  logic ev_ptr_only, ev_clear;

  logic             rf_wr_en, rf_fr_en;
  logic [PTR_W-1:0] rf_wr_addr, rf_fr_addr;
  logic             p_inc, p_dec, do_init, do_clex;
  logic [FLAG_N-1:0] raise_vec;
  logic             summ;

  assign op        = stk_op_e'(op_code);
  assign push_slot = top - ONE;
  assign idx_phys  = top + PTR_W'(op_idx);

  always_comb begin
    ev_overflow  = 1'b0;
    ev_underflow = 1'b0;
    if (op_valid) begin
      case (op)
        OP_PUSH: ev_overflow  = !is_empty(tags, push_slot);
        OP_POP:  ev_underflow = is_empty(tags, top);
        OP_READ: ev_underflow = is_empty(tags, idx_phys);
        OP_XCHG: ev_underflow = is_empty(tags, top) || is_empty(tags, idx_phys);
        default: ;
      endcase
    end
  end

  assign ev_push_ok  = op_valid && (op == OP_PUSH) && !ev_overflow;
  assign ev_pop_ok   = op_valid && (op == OP_POP)  && !ev_underflow;
  assign ev_xchg_ok  = op_valid && (op == OP_XCHG) && !ev_underflow;
  assign ev_ptr_only = op_valid && (op == OP_INCP || op == OP_DECP);
  assign do_init     = op_valid && (op == OP_INIT);
  assign do_clex     = op_valid && (op == OP_CLEX);
  assign ev_clear    = do_init || do_clex;

  assign rf_wr_en   = ev_push_ok || (op_valid && op == OP_WRITE);
  assign rf_wr_addr = ev_push_ok ? push_slot : idx_phys;
  assign rf_fr_en   = ev_pop_ok || (op_valid && op == OP_FREE);
  assign rf_fr_addr = ev_pop_ok ? top : idx_phys;

  assign p_inc = ev_pop_ok  || (op_valid && op == OP_INCP);
  assign p_dec = ev_push_ok || (op_valid && op == OP_DECP);

  always_comb begin
    raise_vec    = (op_valid && op == OP_RAISE) ? exc_in : '0;
    raise_vec[0] = raise_vec[0] | ev_overflow | ev_underflow;
  end

  fpstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_init (do_init),
    .ptr_inc  (p_inc),
    .ptr_dec  (p_dec),
    .top_q    (top)
  );

  fpstk_regfile #(.DEPTH(STK_DEPTH), .W(W), .PTR_W(PTR_W)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_empty (do_init),
    .wr_en     (rf_wr_en),
    .wr_addr   (rf_wr_addr),
    .wr_val    (wr_data[W-1:0]),
    .wr_tag    (classify(wr_data[W-1:0])),
    .sw_en     (ev_xchg_ok),
    .sw_a      (top),
    .sw_b      (idx_phys),
    .fr_en     (rf_fr_en),
    .fr_addr   (rf_fr_addr),
    .rd_addr   (idx_phys),
    .rd_val    (rd_val),
    .tags_flat (tags)
  );

  fpstk_status #(.PTR_W(PTR_W)) u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_init   (do_init),
    .st_clex   (do_clex),
    .raise_vec (raise_vec),
    .cc_we     (op_valid && op == OP_SETCC),
    .cc_val    (cc_in),
    .busy_set  (op_valid && op == OP_SETBSY),
    .msk       (mask),
    .top       (top),
    .sword     (status_word),
    .summ      (summ)
  );

  assign rd_data  = 80'(rd_val);
  assign tag_word = 16'(tags);
  assign irq      = summ;

endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
  parameter int PTR_W = 3,
  parameter int TW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_overflow,
  input logic             ev_underflow,
  input logic             ev_push_ok,
  input logic             ev_pop_ok,
  input logic             ev_ptr_only,
  input logic             ev_clear,
  input logic [PTR_W-1:0] top,
  input logic [TW-1:0]    tag_word,
  input logic [15:0]      status_word
);

  function automatic logic [1:0] tag_sel(input logic [TW-1:0] tw,
                                         input logic [PTR_W-1:0] p);
    return tw[2*p +: 2];
  endfunction

  // R2
  push_moves_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_ok |=> top == $past(top) - PTR_W'(1));

  // R3
  pop_frees_old_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_ok |=> tag_sel(tag_word, $past(top)) == 2'b11);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (status_word[0] && $stable(top) && $stable(tag_word)));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |=> (status_word[0] && $stable(top) && $stable(tag_word)));

  // R8
  ptr_only_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_only |=> $stable(tag_word));

  // R10
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[5:0] != 6'd0 && !ev_clear) |=>
      ((status_word[5:0] & $past(status_word[5:0])) == $past(status_word[5:0])));

endmodule

bind fp_regstack fpstk_chk #(.PTR_W(PTR_W), .TW(2*STK_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_overflow  (ev_overflow),
  .ev_underflow (ev_underflow),
  .ev_push_ok   (ev_push_ok),
  .ev_pop_ok    (ev_pop_ok),
  .ev_ptr_only  (ev_ptr_only),
  .ev_clear     (ev_clear),
  .top          (top),
  .tag_word     (tags),
  .status_word  (status_word)
);

// File: tb/fp_regstack_tb_top.sv
module fp_regstack_tb_top;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] C_PUSH = 4'd1, C_POP = 4'd2, C_READ = 4'd3, C_WRITE = 4'd4,
                         C_XCHG = 4'd5, C_INCP = 4'd6, C_DECP = 4'd7, C_FREE = 4'd8,
                         C_INIT = 4'd9, C_CLEX = 4'd10, C_SETCC = 4'd11,
                         C_SETBSY = 4'd12, C_RAISE = 4'd13;

  localparam logic [79:0] VN = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] VZ = 80'h0;
  localparam logic [79:0] VI = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] VD = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};

  typedef struct packed {
    logic [15:0] req;
    logic [3:0]  op;
    logic [2:0]  idx;
    logic [79:0] d;
    logic [2:0]  etop;
    logic [15:0] etag;
    logic        eie;
    logic [79:0] est0;
  } step_t;

  localparam int NSTEP = 11;
  localparam step_t TBL [NSTEP] = '{
    '{"R2", C_PUSH,  3'd0, VN, 3'd7, 16'h3FFF, 1'b0, VN},
    '{"R2", C_PUSH,  3'd0, VZ, 3'd6, 16'h1FFF, 1'b0, VZ},
    '{"R2", C_PUSH,  3'd0, VI, 3'd5, 16'h1BFF, 1'b0, VI},
    '{"R2", C_PUSH,  3'd0, VD, 3'd4, 16'h1AFF, 1'b0, VD},
    '{"R3", C_POP,   3'd0, VZ, 3'd5, 16'h1BFF, 1'b0, VI},
    '{"R8", C_INCP,  3'd0, VZ, 3'd6, 16'h1BFF, 1'b0, VZ},
    '{"R8", C_DECP,  3'd0, VZ, 3'd5, 16'h1BFF, 1'b0, VI},
    '{"R9", C_FREE,  3'd1, VZ, 3'd5, 16'h3BFF, 1'b0, VI},
    '{"R7", C_XCHG,  3'd2, VZ, 3'd5, 16'hB3FF, 1'b0, VN},
    '{"R6", C_WRITE, 3'd1, VZ, 3'd5, 16'h93FF, 1'b0, VN},
    '{"R5", C_READ,  3'd3, VZ, 3'd5, 16'h93FF, 1'b1, VN}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [2:0]  op_idx = '0;
  logic [79:0] wr_data = '0;
  logic [5:0]  exc_in = '0;
  logic [3:0]  cc_in = '0;
  logic [5:0]  mask = '0;
  logic [79:0] rd_data;
  logic [15:0] tag_word;
  logic [15:0] status_word;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_regstack dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_idx(op_idx), .wr_data(wr_data), .exc_in(exc_in), .cc_in(cc_in),
    .mask(mask), .rd_data(rd_data), .tag_word(tag_word),
    .status_word(status_word), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    op_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Issue one operation; returns at the falling edge after it took effect.
  task automatic do_op(input logic [3:0] c, input logic [2:0] k, input logic [79:0] d);
    @(negedge clk);
    op_code = c; op_idx = k; wr_data = d; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic peek(input logic [2:0] k);
    op_idx = k;
    #1;
  endtask

  function automatic logic [79:0] pv(input int k);
    return VN | 80'(k);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "tag_word", 80'(tag_word), 80'hFFFF);
    chk("R1", "status_word", 80'(status_word), 80'h0);
    chk("R1", "irq", 80'(irq), 80'h0);

    // table walk
    for (int s = 0; s < NSTEP; s++) begin
      do_op(TBL[s].op, TBL[s].idx, TBL[s].d);
      peek(3'd0);
      chk(string'(TBL[s].req), $sformatf("step %0d top", s),
          80'(status_word[13:11]), 80'(TBL[s].etop));
      chk(string'(TBL[s].req), $sformatf("step %0d tag_word", s),
          80'(tag_word), 80'(TBL[s].etag));
      chk(string'(TBL[s].req), $sformatf("step %0d invalid flag", s),
          80'(status_word[0]), 80'(TBL[s].eie));
      chk(string'(TBL[s].req), $sformatf("step %0d ST0", s), rd_data, TBL[s].est0);
    end
    // R7: exchanged partner now holds old ST0 value; R6: ST1 holds written zero
    peek(3'd2);
    chk("R7", "ST2 after exchange", rd_data, VI);
    peek(3'd1);
    chk("R6", "ST1 after relative write", rd_data, VZ);

    // R4 overflow after filling all registers
    do_reset();
    for (int k = 0; k < 8; k++) do_op(C_PUSH, 3'd0, pv(k));
    peek(3'd0);
    chk("R4", "full tag_word", 80'(tag_word), 80'h0000);
    chk("R4", "top wrapped to 0", 80'(status_word[13:11]), 80'h0);
    chk("R4", "no flag before overflow", 80'(status_word[0]), 80'h0);
    do_op(C_PUSH, 3'd0, VZ);
    peek(3'd0);
    chk("R4", "overflow flag", 80'(status_word[0]), 80'h1);
    chk("R4", "top unchanged", 80'(status_word[13:11]), 80'h0);
    chk("R4", "tags unchanged", 80'(tag_word), 80'h0000);
    chk("R4", "ST0 unchanged", rd_data, pv(7));
    peek(3'd7);
    chk("R4", "deepest unchanged", rd_data, pv(0));

    // R5 underflow
    do_reset();
    do_op(C_POP, 3'd0, VZ);
    chk("R5", "pop empty flag", 80'(status_word[0]), 80'h1);
    chk("R5", "pop empty top", 80'(status_word[13:11]), 80'h0);
    chk("R5", "pop empty tags", 80'(tag_word), 80'hFFFF);
    do_op(C_CLEX, 3'd0, VZ);
    do_op(C_PUSH, 3'd0, VN);
    do_op(C_XCHG, 3'd1, VZ);
    peek(3'd0);
    chk("R5", "xchg empty flag", 80'(status_word[0]), 80'h1);
    chk("R5", "xchg empty tags", 80'(tag_word), 80'h3FFF);
    chk("R5", "xchg empty ST0", rd_data, VN);

    // R10 / R11 sticky flags and masking
    do_reset();
    mask = 6'b000000;
    exc_in = 6'b100100;
    do_op(C_RAISE, 3'd0, VZ);
    exc_in = 6'b000000;
    chk("R10", "raised flags", 80'(status_word[5:0]), 80'h24);
    chk("R11", "summary bit", 80'(status_word[7]), 80'h1);
    chk("R11", "irq", 80'(irq), 80'h1);
    do_op(C_RAISE, 3'd0, VZ);
    chk("R10", "flags sticky", 80'(status_word[5:0]), 80'h24);
    mask = 6'b100100;
    #1;
    chk("R11", "masked summary", 80'(status_word[7]), 80'h0);
    chk("R11", "masked irq", 80'(irq), 80'h0);
    mask = 6'b100000;
    #1;
    chk("R11", "partly masked irq", 80'(irq), 80'h1);
    mask = 6'b000000;

    // R12 / R13 codes, busy, top field, clear and init
    do_reset();
    do_op(C_PUSH, 3'd0, pv(3));
    cc_in = 4'b1011;
    do_op(C_SETCC, 3'd0, VZ);
    chk("R12", "codes and top", 80'(status_word), 80'h7B00);
    do_op(C_SETBSY, 3'd0, VZ);
    chk("R12", "busy", 80'(status_word), 80'hFB00);
    exc_in = 6'b100100;
    do_op(C_RAISE, 3'd0, VZ);
    exc_in = '0;
    chk("R10", "flags with codes", 80'(status_word), 80'hFBA4);
    do_op(C_CLEX, 3'd0, VZ);
    chk("R13", "clear exceptions", 80'(status_word), 80'h7B00);
    do_op(C_INIT, 3'd0, VZ);
    peek(3'd7);
    chk("R13", "init status", 80'(status_word), 80'h0000);
    chk("R13", "init tags", 80'(tag_word), 80'hFFFF);
    chk("R13", "init keeps data", rd_data, pv(3));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule